// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block keeps an asynchronous DRAM alive from power-up onward. After reset it holds the memory strobes idle for a settling pause. It then runs a fixed number of wake-up refresh cycles and raises an init-done flag. From then on a free-running interval timer adds one owed refresh each period, and the block refreshes the array without ever interrupting a memory access in progress.

Refresh cycles are issued by strobe ordering in the default variant: the column strobe falls before the row strobe, so the memory steps its own row counter. A parameter selects the other variant. There the column strobe stays high and the block presents a row address from its own wrapping counter while the row strobe is low. The write strobe is held inactive throughout.

The block talks to the access sequencer through two signals. It raises a request while refreshes are owed, and it takes the strobes only in a cycle where the sequencer reports itself idle with its row closed. While refreshes are owed, or while the block owns the strobes, the access grant is withheld. Every owed refresh is then issued back to back in one ownership period. All durations are parameters counted in clock cycles.

Top module: `dram_refresh_sched`

## Requirements
- R1: During reset and in the first cycle after it, ras_n, cas_n and we_n are 1, init_done, acc_allow and ref_req are 0, bus_own is 1, and row_addr is 0.
- R2: For PAUSE_CLKS clock cycles after reset is released, ras_n and cas_n stay at 1. The first strobe activity follows within a few cycles after that.
- R3: After the pause the block issues exactly WAKE_CYCLES refresh cycles with init_done at 0. It then raises init_done, drops bus_own and raises acc_allow. acc_allow is never 1 while init_done is 0.
- R4: In the default variant (RAS_ONLY = 0), cas_n is low for exactly T_CSR cycles before ras_n falls and stays low for exactly T_CHR cycles after ras_n falls.
- R5: ras_n stays low for exactly T_RAS cycles per refresh. Between two refreshes it stays high for at least max(T_RP, T_RC - T_RAS) cycles.
- R6: we_n is 1 at all times.
- R7: After init_done rises, one refresh becomes owed every REFI_CLKS cycles. In the cycle the first one becomes owed, ref_req is 1 and acc_allow is 0. With seq_idle at 1, ras_n falls 3 cycles later.
- R8: bus_own rises only in a cycle after seq_idle was 1. While seq_idle is 0, owed refreshes wait: bus_own stays 0, ras_n and cas_n stay 1, ref_req stays 1, and acc_allow stays 0.
- R9: Owed refreshes count up to MAX_OWED; further timer expiries are dropped. All owed refreshes, and any that become owed during the run, are issued in one unbroken ownership period, after which bus_own falls and acc_allow returns to 1.
- R10: A timer expiry in the same cycle as the completion of a refresh leaves the owed count unchanged, so neither event is lost.
- R11: With RAS_ONLY = 1, cas_n stays 1. row_addr holds steady while ras_n is low, starts at 0 after reset and advances by one modulo 2^ROW_W after every refresh, wake-up cycles included.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| seq_idle | input | 1 | Access sequencer is idle with its row closed |
| ref_req | output | 1 | Refresh owed and waiting for the sequencer to go idle |
| acc_allow | output | 1 | Sequencer may start a new access |
| bus_own | output | 1 | Block drives the memory strobes |
| init_done | output | 1 | Pause and wake-up cycles are complete |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, held high |
| row_addr | output | ROW_W | Row address in the row-addressed variant, 0 otherwise |

## Verification
The interval timer can add an owed refresh in the very cycle that a finishing refresh removes one. The bench holds the sequencer busy until the owed count has saturated. It then releases the sequencer at a cycle computed from the timer phase, so that the eighth completion of the burst lands exactly on the next expiry. The scoreboard then has to see nine refresh cycles in one ownership period: a dropped increment gives eight, and a dropped decrement leaves the block issuing an extra cycle.

// File: rtl/drs_pkg.sv
// Shared types and helpers for the DRAM refresh scheduler.
// Assumes: all durations are expressed in clock cycles.
package drs_pkg;

    // Phase of a single refresh strobe cycle.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_ACT   = 2'd2,
        PH_PRE   = 2'd3
    } drs_phase_e;

    // Top-level scheduler state.
    typedef enum logic [1:0] {
        ST_PAUSE = 2'd0,
        ST_WAKE  = 2'd1,
        ST_IDLE  = 2'd2,
        ST_OWN   = 2'd3
    } drs_state_e;

    // Larger of two integers, used for derived timing limits.
    function automatic int drs_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/drs_interval_timer.sv
// Refresh interval timer: while enabled, pulses tick once every REFI_CLKS cycles.
// Assumes: REFI_CLKS >= 2; the count is held at zero while disabled.
module drs_interval_timer #(
    parameter int REFI_CLKS = 3120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int TW = $clog2(REFI_CLKS);
    localparam logic [TW-1:0] LAST = TW'(REFI_CLKS - 1);

    logic [TW-1:0] cnt_q;

    assign tick = en && (cnt_q == LAST);

    // Count cycles of the interval, wrapping at its end.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/drs_debt_counter.sv
// Owed-refresh counter: adds one per timer tick, removes one per finished refresh,
// saturates at MAX_OWED and holds when both events coincide.
// Assumes: dec is only raised while the count is non-zero.
module drs_debt_counter #(
    parameter int MAX_OWED = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          inc,
    input  logic                          dec,
    output logic [$clog2(MAX_OWED+1)-1:0] owed
);
    localparam int OW = $clog2(MAX_OWED + 1);
    localparam logic [OW-1:0] CAP = OW'(MAX_OWED);

    logic [OW-1:0] owed_q;

    assign owed = owed_q;

    // Update the number of refreshes still owed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owed_q <= '0;
        end else if (inc && !dec) begin
            if (owed_q != CAP) begin
                owed_q <= owed_q + 1'b1;
            end
        end else if (dec && !inc) begin
            owed_q <= owed_q - 1'b1;
        end
    end

    a_r9_owed_cap: assert property (@(posedge clk) disable iff (!rst_n)
        owed_q <= CAP);

    a_r9_no_dec_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (owed_q != '0));

    a_r10_tick_meets_done: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && dec) |=> $stable(owed_q));

endmodule

// File: rtl/drs_cycle_seq.sv
// Single refresh strobe cycle: setup, row strobe low, precharge.
// RAS_ONLY = 0: column strobe leads the row strobe (memory-internal row counter).
// RAS_ONLY = 1: column strobe stays high; a local wrapping row counter is presented.
// Assumes: T_CHR < T_RAS; start is only sampled while idle.
module drs_cycle_seq #(
    parameter bit RAS_ONLY = 1'b0,
    parameter int T_CSR    = 1,
    parameter int T_CHR    = 3,
    parameter int T_RAS    = 12,
    parameter int T_PRE    = 10,
    parameter int ROW_W    = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic             ras_n,
    output logic             cas_n,
    output logic [ROW_W-1:0] row_addr
);
    import drs_pkg::*;

    localparam int LMAX  = drs_max(drs_max(T_CSR, T_RAS), T_PRE);
    localparam int CNT_W = $clog2(LMAX + 1);
    localparam logic [CNT_W-1:0] L_SET = CNT_W'(T_CSR - 1);
    localparam logic [CNT_W-1:0] L_ACT = CNT_W'(T_RAS - 1);
    localparam logic [CNT_W-1:0] L_PRE = CNT_W'(T_PRE - 1);
    localparam logic [CNT_W-1:0] L_CHR = CNT_W'(T_CHR);

    drs_phase_e       phase_q;
    logic [CNT_W-1:0] cnt_q;

    assign busy  = (phase_q != PH_IDLE);
    assign done  = (phase_q == PH_PRE) && (cnt_q == L_PRE);
    assign ras_n = (phase_q != PH_ACT);

    // Step through the phases of one refresh cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q <= PH_SETUP;
                        cnt_q   <= '0;
                    end
                end
                PH_SETUP: begin
                    if (cnt_q == L_SET) begin
                        phase_q <= PH_ACT;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_ACT: begin
                    if (cnt_q == L_ACT) begin
                        phase_q <= PH_PRE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    if (cnt_q == L_PRE) begin
                        phase_q <= PH_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    generate
        if (RAS_ONLY) begin : g_row_addressed
            logic [ROW_W-1:0] row_q;

            assign cas_n    = 1'b1;
            assign row_addr = row_q;

            // Advance the local row pointer after each finished refresh.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    row_q <= '0;
                end else if (done) begin
                    row_q <= row_q + 1'b1;
                end
            end

            a_r11_row_held: assert property (@(posedge clk) disable iff (!rst_n)
                !ras_n |-> $stable(row_addr));
        end else begin : g_cas_first
            assign cas_n    = !((phase_q == PH_SETUP) ||
                                ((phase_q == PH_ACT) && (cnt_q < L_CHR)));
            assign row_addr = '0;

            a_r4_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(ras_n) |-> ($past(cas_n) == 1'b0) && !cas_n);
        end
    endgenerate

    // Checker state: length of the current low and high runs of the row strobe.
    logic [CNT_W:0] low_run_q;
    logic [CNT_W:0] high_run_q;
    localparam logic [CNT_W:0] HI_CAP = (CNT_W+1)'(T_PRE);

    // Track strobe run lengths for the width assertions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run_q  <= '0;
            high_run_q <= HI_CAP;
        end else begin
            low_run_q  <= ras_n ? '0 : low_run_q + 1'b1;
            high_run_q <= !ras_n ? '0 :
                          (high_run_q == HI_CAP) ? HI_CAP : high_run_q + 1'b1;
        end
    end

    a_r5_ras_low_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (low_run_q == (CNT_W+1)'(T_RAS)));

    a_r5_ras_high_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (high_run_q >= HI_CAP));

endmodule

// File: rtl/dram_refresh_sched.sv
// DRAM refresh and initialization scheduler.
// Runs a power-up pause, a fixed number of wake-up refreshes, then periodic
// refreshes owed by an interval timer, taking the strobes only while the
// access sequencer reports idle.
// Assumes: all timing parameters are in clock cycles; seq_idle is synchronous.
module dram_refresh_sched #(
    parameter bit RAS_ONLY    = 1'b0,
    parameter int PAUSE_CLKS  = 40000,
    parameter int WAKE_CYCLES = 8,
    parameter int REFI_CLKS   = 3120,
    parameter int MAX_OWED    = 8,
    parameter int T_CSR       = 1,
    parameter int T_CHR       = 3,
    parameter int T_RAS       = 12,
    parameter int T_RP        = 8,
    parameter int T_RC        = 22,
    parameter int ROW_W       = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seq_idle,
    output logic             ref_req,
    output logic             acc_allow,
    output logic             bus_own,
    output logic             init_done,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic [ROW_W-1:0] row_addr
);
    import drs_pkg::*;

    localparam int T_PRE   = drs_max(T_RP, T_RC - T_RAS);
    localparam int PAUSE_W = $clog2(PAUSE_CLKS);
    localparam int WAKE_W  = $clog2(WAKE_CYCLES + 1);
    localparam int OW      = $clog2(MAX_OWED + 1);
    localparam logic [PAUSE_W-1:0] PAUSE_LAST = PAUSE_W'(PAUSE_CLKS - 1);
    localparam logic [WAKE_W-1:0]  WAKE_N     = WAKE_W'(WAKE_CYCLES);

    drs_state_e        st_q;
    logic [PAUSE_W-1:0] pause_q;
    logic [WAKE_W-1:0]  wake_q;
    logic [OW-1:0]      owed;
    logic               tick;
    logic               seq_start;
    logic               seq_busy;
    logic               seq_done;
    logic               owed_any;

    assign owed_any  = (owed != '0);
    assign init_done = (st_q == ST_IDLE) || (st_q == ST_OWN);
    assign bus_own   = (st_q != ST_IDLE);
    assign ref_req   = (st_q == ST_IDLE) && owed_any;
    assign acc_allow = (st_q == ST_IDLE) && !owed_any;
    assign we_n      = 1'b1;

    // Launch a refresh whenever the strobes are owned and one is still due.
    always_comb begin
        seq_start = 1'b0;
        if (!seq_busy) begin
            if (st_q == ST_WAKE) begin
                seq_start = (wake_q < WAKE_N);
            end else if (st_q == ST_OWN) begin
                seq_start = owed_any;
            end
        end
    end

    // Scheduler state: pause, wake-up, idle, owning the strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_PAUSE;
            pause_q <= '0;
            wake_q  <= '0;
        end else begin
            case (st_q)
                ST_PAUSE: begin
                    if (pause_q == PAUSE_LAST) begin
                        st_q <= ST_WAKE;
                    end else begin
                        pause_q <= pause_q + 1'b1;
                    end
                end
                ST_WAKE: begin
                    if (seq_done) begin
                        wake_q <= wake_q + 1'b1;
                    end
                    if ((wake_q == WAKE_N) && !seq_busy) begin
                        st_q <= ST_IDLE;
                    end
                end
                ST_IDLE: begin
                    if (owed_any && seq_idle) begin
                        st_q <= ST_OWN;
                    end
                end
                default: begin
                    if (!owed_any && !seq_busy) begin
                        st_q <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    drs_interval_timer #(
        .REFI_CLKS (REFI_CLKS)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (init_done),
        .tick  (tick)
    );

    drs_debt_counter #(
        .MAX_OWED (MAX_OWED)
    ) u_debt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (tick),
        .dec   (seq_done && (st_q == ST_OWN)),
        .owed  (owed)
    );

    drs_cycle_seq #(
        .RAS_ONLY (RAS_ONLY),
        .T_CSR    (T_CSR),
        .T_CHR    (T_CHR),
        .T_RAS    (T_RAS),
        .T_PRE    (T_PRE),
        .ROW_W    (ROW_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (seq_start),
        .busy     (seq_busy),
        .done     (seq_done),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .row_addr (row_addr)
    );

    a_r8_grant_only_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_own) |-> $past(seq_idle));

    a_r8_quiet_when_released: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_own |-> (ras_n && cas_n));

    a_r2_quiet_pause: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PAUSE) |-> (ras_n && cas_n));

endmodule

// File: tb/dram_refresh_sched_bench.sv
`timescale 1ns/1ps
module dram_refresh_sched_bench;
    localparam int PAUSE = 300;
    localparam int REFI  = 200;
    localparam int WAKE  = 8;
    localparam int MAXO  = 8;
    localparam int T_CSR = 1;
    localparam int T_CHR = 3;
    localparam int T_RAS = 12;
    localparam int T_RP  = 8;
    localparam int T_RC  = 22;
    localparam int RW    = 4;
    localparam int T_PRE = (T_RP > T_RC - T_RAS) ? T_RP : (T_RC - T_RAS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic seq_idle = 1'b1;
    logic ref_req, acc_allow, bus_own, init_done, ras_n, cas_n, we_n;
    logic [RW-1:0] row_addr;
    logic ro_req, ro_allow, ro_own, ro_done, ro_ras, ro_cas, ro_we;
    logic [RW-1:0] ro_row;

    always #2.5 clk = ~clk;

    dram_refresh_sched #(
        .RAS_ONLY(1'b0), .PAUSE_CLKS(PAUSE), .WAKE_CYCLES(WAKE), .REFI_CLKS(REFI),
        .MAX_OWED(MAXO), .T_CSR(T_CSR), .T_CHR(T_CHR), .T_RAS(T_RAS),
        .T_RP(T_RP), .T_RC(T_RC), .ROW_W(RW)
    ) u_dram_refresh_sched (
        .clk(clk), .rst_n(rst_n), .seq_idle(seq_idle), .ref_req(ref_req),
        .acc_allow(acc_allow), .bus_own(bus_own), .init_done(init_done),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .row_addr(row_addr)
    );

    dram_refresh_sched #(
        .RAS_ONLY(1'b1), .PAUSE_CLKS(PAUSE), .WAKE_CYCLES(WAKE), .REFI_CLKS(REFI),
        .MAX_OWED(MAXO), .T_CSR(T_CSR), .T_CHR(T_CHR), .T_RAS(T_RAS),
        .T_RP(T_RP), .T_RC(T_RC), .ROW_W(RW)
    ) u_dram_refresh_sched_ro (
        .clk(clk), .rst_n(rst_n), .seq_idle(seq_idle), .ref_req(ro_req),
        .acc_allow(ro_allow), .bus_own(ro_own), .init_done(ro_done),
        .ras_n(ro_ras), .cas_n(ro_cas), .we_n(ro_we), .row_addr(ro_row)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;
    int exp_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Driver side of the scoreboard: tag 0 = wake-up cycle, 1 = periodic refresh.
    task automatic push_expected(input int tag, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(tag);
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // Monitor state for the column-first instance.
    int falls = 0, cas_run = 0, low_run = 0, high_run = 0, cas_after = 0;
    int first_cas = -1, last_fall = -1, own_rises = 0, we_bad = 0, early_acc = 0;
    logic p_ras = 1'b1, p_own = 1'b1;
    // Monitor state for the row-addressed instance.
    int ro_falls = 0, ro_cas_low = 0;
    logic p_ro_ras = 1'b1;

    // Monitor: pops one expected item per row-strobe fall and checks strobe timing.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!cas_n && first_cas < 0) first_cas = cyc;
            if (p_ras && !ras_n) begin
                falls++;
                last_fall = cyc;
                chk(cas_run == T_CSR, "R4", "CAS lead cycles", cas_run, T_CSR);
                if (falls > 1)
                    chk(high_run >= T_PRE, "R5", "RAS high cycles", high_run, T_PRE);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected refresh cycle number", falls, 0);
                end else begin
                    int tag;
                    tag = exp_q.pop_front();
                    chk(tag == int'(init_done), "R3", "cycle kind", int'(init_done), tag);
                end
                low_run = 1;
                cas_after = cas_n ? 0 : 1;
            end else if (!ras_n) begin
                low_run++;
                if (!cas_n) cas_after++;
            end
            if (!p_ras && ras_n) begin
                chk(low_run == T_RAS, "R5", "RAS low cycles", low_run, T_RAS);
                chk(cas_after == T_CHR, "R4", "CAS hold cycles", cas_after, T_CHR);
                high_run = 1;
            end else if (ras_n) begin
                high_run++;
            end
            if (ras_n && !cas_n) cas_run++;
            else cas_run = 0;
            if (!we_n || !ro_we) we_bad++;
            if (acc_allow && !init_done) early_acc++;
            if (!p_own && bus_own) own_rises++;
            p_ras = ras_n;
            p_own = bus_own;

            if (!ro_cas) ro_cas_low++;
            if (p_ro_ras && !ro_ras) begin
                chk(int'(ro_row) == (ro_falls % (1 << RW)), "R11", "row address",
                    int'(ro_row), ro_falls % (1 << RW));
                ro_falls++;
            end
            p_ro_ras = ro_ras;
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "WD", "watchdog expired at cycle", cyc, 0);
        summary();
        $finish;
    end

    initial begin
        int rel, t0, base_rises;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(ras_n == 1'b1, "R1", "ras_n in reset", ras_n, 1);
        chk(cas_n == 1'b1, "R1", "cas_n in reset", cas_n, 1);
        chk(we_n == 1'b1, "R1", "we_n in reset", we_n, 1);
        chk(init_done == 1'b0, "R1", "init_done in reset", init_done, 0);
        chk(acc_allow == 1'b0, "R1", "acc_allow in reset", acc_allow, 0);
        chk(ref_req == 1'b0, "R1", "ref_req in reset", ref_req, 0);
        chk(bus_own == 1'b1, "R1", "bus_own in reset", bus_own, 1);
        chk(ro_row == '0, "R1", "row_addr in reset", int'(ro_row), 0);

        push_expected(0, WAKE);
        rst_n = 1'b1;
        rel = cyc;
        @(negedge clk);
        chk(ras_n && cas_n && !init_done, "R1", "strobes idle after release", int'(ras_n & cas_n), 1);

        while (!init_done && cyc < rel + PAUSE + 2000) @(negedge clk);
        t0 = cyc;
        // R2: pause before the first strobe
        chk(first_cas - rel >= PAUSE && first_cas - rel <= PAUSE + 4, "R2",
            "first strobe delay", first_cas - rel, PAUSE + 1);
        // R3: wake-up cycles then release
        chk(falls == WAKE, "R3", "wake-up cycles", falls, WAKE);
        chk(exp_q.size() == 0, "R3", "wake items left", exp_q.size(), 0);
        chk(t0 - rel >= PAUSE + WAKE * (T_RAS + T_PRE), "R3", "init length",
            t0 - rel, PAUSE + WAKE * (T_RAS + T_PRE));
        chk(acc_allow == 1'b1 && bus_own == 1'b0, "R3", "access released",
            int'(acc_allow), 1);
        chk(ro_done == 1'b1, "R3", "row-addressed init_done", int'(ro_done), 1);

        // R7: periodic refreshes with the sequencer idle
        push_expected(1, 3);
        wait_until(t0 + REFI);
        chk(ref_req == 1'b1, "R7", "ref_req when owed", int'(ref_req), 1);
        chk(acc_allow == 1'b0, "R7", "acc_allow when owed", int'(acc_allow), 0);
        wait_until(t0 + REFI + 10);
        chk(last_fall - t0 == REFI + 3, "R7", "first refresh delay", last_fall - t0, REFI + 3);
        wait_until(t0 + 3 * REFI + 60);
        chk(falls == WAKE + 3, "R7", "refreshes after three intervals", falls, WAKE + 3);
        chk(exp_q.size() == 0, "R7", "items left", exp_q.size(), 0);

        // R8: sequencer busy for five intervals
        seq_idle = 1'b0;
        wait_until(t0 + 8 * REFI + 20);
        chk(falls == WAKE + 3, "R8", "no refresh while busy", falls, WAKE + 3);
        chk(ref_req == 1'b1, "R8", "ref_req while busy", int'(ref_req), 1);
        chk(acc_allow == 1'b0, "R8", "acc_allow while owed", int'(acc_allow), 0);
        chk(bus_own == 1'b0 && ras_n && cas_n, "R8", "strobes released", int'(bus_own), 0);
        push_expected(1, 5);
        base_rises = own_rises;
        seq_idle = 1'b1;
        wait_until(t0 + 8 * REFI + 180);
        // R9: backlog drained in one ownership period
        chk(exp_q.size() == 0, "R9", "backlog items left", exp_q.size(), 0);
        chk(own_rises == base_rises + 1, "R9", "ownership periods", own_rises - base_rises, 1);
        chk(acc_allow == 1'b1 && bus_own == 1'b0, "R9", "released after backlog",
            int'(acc_allow), 1);

        // R9/R10: saturate, then land a completion on a timer expiry
        seq_idle = 1'b0;
        wait_until(t0 + 19 * REFI + 7);
        chk(ref_req == 1'b1, "R9", "ref_req while saturated", int'(ref_req), 1);
        push_expected(1, MAXO + 1);
        base_rises = own_rises;
        seq_idle = 1'b1;
        wait_until(t0 + 20 * REFI + 60);
        chk(exp_q.size() == 0, "R10", "items left after coincident expiry", exp_q.size(), 0);
        chk(falls == WAKE + 3 + 5 + MAXO + 1, "R10", "total refreshes", falls,
            WAKE + 3 + 5 + MAXO + 1);
        chk(own_rises == base_rises + 1, "R9", "saturated burst ownership periods",
            own_rises - base_rises, 1);

        // R6, R3, R11 summaries
        chk(we_bad == 0, "R6", "we_n low samples", we_bad, 0);
        chk(early_acc == 0, "R3", "acc_allow before init_done", early_acc, 0);
        chk(ro_cas_low == 0, "R11", "cas_n low samples", ro_cas_low, 0);
        chk(ro_falls == falls, "R11", "row-addressed refresh count", ro_falls, falls);

        summary();
        $finish;
    end

endmodule